// File: doc/BRIEF.md
# Standby Current Learning Filter

This block holds a battery gauge's learned estimate of the system's standby current. Each time reset is applied it loads a starting estimate from a 3-bit field of a configuration byte. While the gauge runs, the block refines that estimate with a first-order exponential average of discharge-current samples. A sample counts only when it falls inside an acceptance window. The window's lower edge is a programmable magnitude filter threshold. Its upper edge is twice the programmed initial value.

The same doubled initial value also decides whether a capacity-learning cycle may continue. When the running average discharge current supplied by the gauge is at or below that value, the block raises a disqualify flag. The estimate is kept in sense-voltage counts of 57.1 µV each.

Both configuration fields are scaled up to the sample width before any comparison. The 3-bit initial code is shifted left by `INIT_SHIFT`. The 4-bit filter code is shifted left by `DMF_SHIFT`.

Top module: `scl_standby_learn`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `standby_est` becomes `cfg_standby[6:4] << INIT_SHIFT`, which is code×16 with the defaults, and `learn_disqualify` becomes 0.
- R2: Bit 7 and bits 3:0 of `cfg_standby` have no effect on `standby_est`, on the acceptance window or on `learn_disqualify`.
- R3: A sample is accepted only when `sample_valid` is 1, `discharging` is 1 and `sample_mag` lies within the acceptance window. Every other sample is rejected.
- R4: For an accepted sample, the internal value `acc` has `AVG_SHIFT` (4) fraction bits and becomes `acc + ((sample_mag·16 − acc) >>> 4)`, using an arithmetic shift. `standby_est` equals `acc >> 4` and shows the new value one clock after the accepting edge.
- R5: A sample taken while `discharging` is 0, or while `sample_valid` is 0, leaves `standby_est` unchanged.
- R6: The lower window edge is `cfg_filter[7:4] << DMF_SHIFT`, which is code×4 with the defaults. A sample must be strictly greater than this edge. Bits 3:0 of `cfg_filter` have no effect.
- R7: The upper window edge is `cfg_standby[6:4] << (INIT_SHIFT+1)`, which is code×32 with the defaults. A sample equal to this edge is accepted and one greater is rejected.
- R8: `learn_disqualify` is registered. One clock after an edge that samples `avg_current`, it equals 1 when `avg_current` is at or below the upper window edge and 0 otherwise.
- R9: The filter never stalls and never overshoots. Under repeated accepted samples of value S, `standby_est` ends exactly at S when falling toward it, and ends at S or S−1 when rising toward it, without ever exceeding S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial estimate |
| sample_valid | input | 1 | Marks a new current sample |
| sample_mag | input | SAMPLE_W | Current sample magnitude in sense counts |
| discharging | input | 1 | 1 when the sample is a discharge current |
| cfg_standby | input | 8 | Initial standby code in bits 6:4; other bits are unused here |
| cfg_filter | input | 8 | Magnitude filter code in bits 7:4; other bits are unused here |
| avg_current | input | SAMPLE_W | Running average discharge current from the gauge |
| standby_est | output | SAMPLE_W | Learned standby current estimate |
| learn_disqualify | output | 1 | Capacity-learning cycle disqualified |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. Both the filter update and the disqualify decision are registered, and no pipeline lies between them. The bench changes inputs on the falling edge. It advances the reference model once for each rising edge, then compares `standby_est` and `learn_disqualify` at the next falling edge. A change to the estimate therefore never appears a cycle early or late without being caught. After a reset, the loaded value is compared at the first falling edge that follows the edge where reset is sampled.

// File: rtl/scl_pkg.sv
package scl_pkg;
   // Field positions inside the two configuration bytes.
   localparam int unsigned CFG_INIT_MSB = 6;
   localparam int unsigned CFG_INIT_LSB = 4;
   localparam int unsigned CFG_DMF_MSB  = 7;
   localparam int unsigned CFG_DMF_LSB  = 4;
   localparam int unsigned INIT_CODE_W  = CFG_INIT_MSB - CFG_INIT_LSB + 1;
   localparam int unsigned DMF_CODE_W   = CFG_DMF_MSB - CFG_DMF_LSB + 1;

   // How the estimate leaves the fractional accumulator.
   typedef enum logic {
      OUT_TRUNC = 1'b0,
      OUT_ROUND = 1'b1
   } scl_out_mode_e;

   // Timing of the disqualify decision.
   typedef enum logic {
      DQ_COMB = 1'b0,
      DQ_REG  = 1'b1
   } scl_dq_mode_e;
endpackage

// File: rtl/scl_window.sv
module scl_window
   import scl_pkg::*;
#(
   parameter int unsigned W          = 12,
   parameter int unsigned INIT_SHIFT = 4,
   parameter int unsigned DMF_SHIFT  = 2
) (
   input  logic                   sample_valid,
   input  logic                   discharging,
   input  logic [W-1:0]           sample_mag,
   input  logic [INIT_CODE_W-1:0] init_code,
   input  logic [DMF_CODE_W-1:0]  dmf_code,
   output logic [W-1:0]           lo_thr,
   output logic [W-1:0]           hi_thr,
   output logic                   accept
);
   localparam int unsigned HI_SHIFT = INIT_SHIFT + 1;

   if (W < INIT_CODE_W + HI_SHIFT) begin : g_bad_init_w
      $error("scl_window: W too small for scaled initial code");
   end
   if (W < DMF_CODE_W + DMF_SHIFT) begin : g_bad_dmf_w
      $error("scl_window: W too small for scaled filter code");
   end

   logic [W-1:0] init_ext;
   logic [W-1:0] dmf_ext;
   logic         above_lo;
   logic         within_hi;

   always_comb begin
      init_ext  = {{(W-INIT_CODE_W){1'b0}}, init_code};
      dmf_ext   = {{(W-DMF_CODE_W){1'b0}}, dmf_code};
      lo_thr    = dmf_ext << DMF_SHIFT;
      hi_thr    = init_ext << HI_SHIFT;
      above_lo  = (sample_mag > lo_thr);
      within_hi = (sample_mag <= hi_thr);
      accept    = sample_valid & discharging & above_lo & within_hi;
   end

   // R7: the upper edge is always twice the reset value of the estimate
   always_comb begin
      a_r7_hi_is_double: assert (hi_thr == (init_ext << INIT_SHIFT) + (init_ext << INIT_SHIFT));
   end
endmodule

// File: rtl/scl_ewma.sv
module scl_ewma
   import scl_pkg::*;
#(
   parameter int unsigned   W     = 12,
   parameter int unsigned   SHIFT = 4,
   parameter scl_out_mode_e OMODE = OUT_TRUNC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] load_val,
   input  logic         accept,
   input  logic [W-1:0] sample,
   output logic [W-1:0] est
);
   localparam int unsigned AW = W + SHIFT;

   if (SHIFT < 1) begin : g_bad_shift
      $error("scl_ewma: SHIFT must be at least 1");
   end

   logic [AW-1:0]        acc_q;
   logic [AW-1:0]        acc_n;
   logic [AW-1:0]        sample_fx;
   logic signed [AW:0]   diff;
   logic signed [AW:0]   step;
   logic signed [AW:0]   sum;

   always_comb begin
      sample_fx = {sample, {SHIFT{1'b0}}};
      diff      = $signed({1'b0, sample_fx}) - $signed({1'b0, acc_q});
      step      = diff >>> SHIFT;
      sum       = $signed({1'b0, acc_q}) + step;
      acc_n     = sum[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= {load_val, {SHIFT{1'b0}}};
      end else if (accept) begin
         acc_q <= acc_n;
      end
   end

   if (OMODE == OUT_ROUND) begin : g_round
      logic [AW:0] rnd;
      always_comb begin
         rnd = {1'b0, acc_q} + (AW+1)'(1 << (SHIFT-1));
         est = rnd[AW] ? {W{1'b1}} : rnd[AW-1:SHIFT];
      end
   end else begin : g_trunc
      always_comb est = acc_q[AW-1:SHIFT];
   end

   // R1: the cycle after reset the accumulator holds the loaded value
   a_r1_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> acc_q == {$past(load_val), {SHIFT{1'b0}}});

   // R5: without an accepted sample the accumulator holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(acc_q));

   // R9: a rising update never passes the sample and never moves backward
   a_r9_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sample_fx >= acc_q) |=> (acc_q <= $past(sample_fx) && acc_q >= $past(acc_q)));

   // R9: a falling update never passes the sample and never moves upward
   a_r9_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sample_fx < acc_q) |=> (acc_q >= $past(sample_fx) && acc_q < $past(acc_q)));
endmodule

// File: rtl/scl_disq.sv
module scl_disq
   import scl_pkg::*;
#(
   parameter int unsigned  W     = 12,
   parameter scl_dq_mode_e DMODE = DQ_REG
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] avg_current,
   input  logic [W-1:0] hi_thr,
   output logic         disq
);
   logic low_avg;
   always_comb low_avg = (avg_current <= hi_thr);

   if (DMODE == DQ_REG) begin : g_reg
      logic disq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) disq_q <= 1'b0;
         else        disq_q <= low_avg;
      end
      always_comb disq = disq_q;

      // R8: the flag reflects the average seen at the previous edge
      a_r8_disq_follow: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> disq == ($past(avg_current) <= $past(hi_thr)));
      // R1: the flag is cleared by reset
      a_r1_disq_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> !disq);
   end else begin : g_comb
      always_comb disq = rst_n & low_avg;
   end
endmodule

// File: rtl/scl_standby_learn.sv
module scl_standby_learn
   import scl_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 12,
   parameter int unsigned INIT_SHIFT = 4,
   parameter int unsigned DMF_SHIFT  = 2,
   parameter int unsigned AVG_SHIFT  = 4,
   parameter bit          ROUND_OUT  = 1'b0,
   parameter bit          REG_DISQ   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_valid,
   input  logic [SAMPLE_W-1:0] sample_mag,
   input  logic                discharging,
   input  logic [7:0]          cfg_standby,
   input  logic [7:0]          cfg_filter,
   input  logic [SAMPLE_W-1:0] avg_current,
   output logic [SAMPLE_W-1:0] standby_est,
   output logic                learn_disqualify
);
   localparam scl_out_mode_e OMODE = ROUND_OUT ? OUT_ROUND : OUT_TRUNC;
   localparam scl_dq_mode_e  DMODE = REG_DISQ ? DQ_REG : DQ_COMB;

   if (SAMPLE_W < INIT_CODE_W + INIT_SHIFT + 1) begin : g_bad_w
      $error("scl_standby_learn: SAMPLE_W too small");
   end

   logic [INIT_CODE_W-1:0] init_code;
   logic [DMF_CODE_W-1:0]  dmf_code;
   logic [SAMPLE_W-1:0]    init_scaled;
   logic [SAMPLE_W-1:0]    lo_thr;
   logic [SAMPLE_W-1:0]    hi_thr;
   logic                   accept;

   always_comb begin
      init_code   = cfg_standby[CFG_INIT_MSB:CFG_INIT_LSB];
      dmf_code    = cfg_filter[CFG_DMF_MSB:CFG_DMF_LSB];
      init_scaled = {{(SAMPLE_W-INIT_CODE_W){1'b0}}, init_code} << INIT_SHIFT;
   end

   scl_window #(
      .W(SAMPLE_W), .INIT_SHIFT(INIT_SHIFT), .DMF_SHIFT(DMF_SHIFT)
   ) u_window (
      .sample_valid(sample_valid),
      .discharging (discharging),
      .sample_mag  (sample_mag),
      .init_code   (init_code),
      .dmf_code    (dmf_code),
      .lo_thr      (lo_thr),
      .hi_thr      (hi_thr),
      .accept      (accept)
   );

   scl_ewma #(
      .W(SAMPLE_W), .SHIFT(AVG_SHIFT), .OMODE(OMODE)
   ) u_ewma (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_val(init_scaled),
      .accept  (accept),
      .sample  (sample_mag),
      .est     (standby_est)
   );

   scl_disq #(
      .W(SAMPLE_W), .DMODE(DMODE)
   ) u_disq (
      .clk        (clk),
      .rst_n      (rst_n),
      .avg_current(avg_current),
      .hi_thr     (hi_thr),
      .disq       (learn_disqualify)
   );

   // R3: charging or missing strobe keeps the estimate at the ports
   a_r3_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid || !discharging) |=> $stable(standby_est));

   // R6: a sample at or under the lower edge leaves the estimate alone
   a_r6_low_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_mag <= lo_thr) |=> $stable(standby_est));
endmodule

// File: tb/scl_standby_learn_test.sv
module scl_standby_learn_test;
   localparam int W = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_valid = 1'b0;
   logic [W-1:0]  sample_mag = '0;
   logic          discharging = 1'b0;
   logic [7:0]    cfg_standby = 8'h00;
   logic [7:0]    cfg_filter = 8'h00;
   logic [W-1:0]  avg_current = '0;
   logic [W-1:0]  standby_est;
   logic          learn_disqualify;

   int n_checks = 0;
   int n_err = 0;
   int model_acc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scl_standby_learn uut (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_mag(sample_mag), .discharging(discharging),
      .cfg_standby(cfg_standby), .cfg_filter(cfg_filter),
      .avg_current(avg_current), .standby_est(standby_est),
      .learn_disqualify(learn_disqualify)
   );

   function automatic int lo_of(logic [7:0] f);
      return int'(f[7:4]) * 4;
   endfunction
   function automatic int hi_of(logic [7:0] s);
      return int'(s[6:4]) * 32;
   endfunction
   function automatic int next_acc(int acc, int mag);
      int d;
      d = mag * 16 - acc;
      return acc + (d >>> 4);
   endfunction

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic [7:0] s, logic [7:0] f);
      @(negedge clk);
      rst_n = 1'b0; cfg_standby = s; cfg_filter = f;
      sample_valid = 1'b0; discharging = 1'b0;
      @(negedge clk);
      model_acc = int'(s[6:4]) * 16 * 16;
      check("R1 est", int'(standby_est), model_acc / 16);
      check("R1 disq", int'(learn_disqualify), 0);
      rst_n = 1'b1;
   endtask

   // inputs applied at the falling edge, results read at the next one
   task automatic step(bit v, bit dis, int mag, int avg, string tag);
      bit acc_ok;
      sample_valid = v; discharging = dis;
      sample_mag = W'(mag); avg_current = W'(avg);
      acc_ok = v && dis && (mag > lo_of(cfg_filter)) && (mag <= hi_of(cfg_standby));
      if (acc_ok) model_acc = next_acc(model_acc, mag);
      @(negedge clk);
      check({tag, " est"}, int'(standby_est), model_acc / 16);
      check("R8 disq", int'(learn_disqualify), (avg <= hi_of(cfg_standby)) ? 1 : 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      int lo;
      int hi;
      int e;
      void'($urandom(32'd20240607));

      // R1: init code 5 -> est 80, window (24,160]
      do_reset(8'h5A, 8'h6F);
      lo = 24; hi = 160;
      // R5: rejections leave the estimate unchanged
      step(1'b1, 1'b0, 100, 0, "R5 charging");
      step(1'b0, 1'b1, 100, 0, "R5 no strobe");
      // R6 / R7 boundaries
      step(1'b1, 1'b1, lo, hi, "R6 at lo");
      step(1'b1, 1'b1, lo + 1, hi + 1, "R6 lo+1");
      step(1'b1, 1'b1, hi + 1, 5, "R7 hi+1");
      step(1'b1, 1'b1, hi, 500, "R7 at hi");
      // R4: explicit value after one update from a fresh reset, 80 -> 160
      do_reset(8'hD0, 8'h60);
      step(1'b1, 1'b1, 160, 0, "R4 one step");
      check("R4 value", int'(standby_est), 85);
      // R2: unused bits of cfg_standby change, nothing else does
      cfg_standby = 8'hDF;
      step(1'b1, 1'b1, 160, 160, "R2 unused bits");
      check("R2 hi", int'(learn_disqualify), 1);
      // R6: unused nibble of cfg_filter has no effect on the lower edge
      cfg_filter = 8'h6F;
      step(1'b1, 1'b1, 24, 161, "R6 low nibble");
      check("R8 above", int'(learn_disqualify), 0);

      // R9: rising toward 160 settles at 159 or 160, never above
      for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 160, 0, "R9 up");
      e = int'(standby_est);
      check("R9 up settle", (e == 159 || e == 160) ? 1 : 0, 1);
      // R9: falling toward 25 reaches exactly 25
      for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 25, 0, "R9 down");
      check("R9 down exact", int'(standby_est), 25);

      // constrained random with several configurations (R3 R4 R5 R8)
      for (int r = 0; r < 6; r++) begin
         logic [7:0] s;
         logic [7:0] f;
         s = 8'($urandom);
         if (s[6:4] == 3'd0) s[6:4] = 3'd3;
         f = 8'($urandom);
         do_reset(s, f);
         for (int i = 0; i < 150; i++) begin
            int m;
            m = int'($urandom % 32'(hi_of(s) + 48));
            step(($urandom % 4) != 0, ($urandom % 5) != 0, m,
                 int'($urandom % 32'(hi_of(s) + 64)), "R3 R4 random");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule